// File: doc/BRIEF.md
# Delayed Coincidence Event Trigger

This block sits behind the per-pixel discriminators of a 127-pixel hexagonal detector and turns their hit strobes into global triggers. Each strobe carries a pixel index, a flag that marks it as proton-like (otherwise electron-like), and a timestamp counted in 10 ns ticks. Electron hits are held as open candidates in a short queue kept in arrival order. A later proton hit qualifies as a coincidence when two conditions both hold. First, it lands on the candidate's own pixel or on one of that pixel's immediate hexagonal neighbours. Second, its time-of-flight delay falls inside a programmable window, which is 12 µs to 40 µs by default.

A coincidence produces a one-cycle event record. The record holds both pixel indices and both timestamps, which downstream readout uses to pull waveforms around the two hit neighbourhoods. A candidate that ages past the window is retired. If it was never paired and singles recording is enabled, it produces a singles trigger. Protons that match only electrons that are already paired are reported as extra hits.

Pixels are numbered row by row across the hexagon. There are 2R+1 rows of lengths R+1, R+2, …, 2R+1, …, R+1, and the default radius is R = 6. Within a row, indices increase along the row.

Top module: `coinc_trigger`

## Requirements
- R1: After reset, coinc_valid_o, extra_valid_o and single_valid_o are low and no candidate is held.
- R2: Two pixels are adjacent when they are equal or are one of the six hexagonal neighbours under the row-by-row numbering. With the default radius, pixel 63 neighbours 50, 51, 62, 64, 75 and 76. Pixel 0 neighbours 7, pixel 2 does not neighbour 7, and pixels 69 and 70 are not adjacent.
- R3: A proton matches a candidate only when its timestamp minus the candidate's lies within [WIN_MIN, WIN_MAX] inclusive. With the defaults, a delay of 1199 ticks is rejected, and delays of 1200 and 4000 ticks are accepted.
- R4: A proton that matches an unpaired candidate raises coinc_valid_o for one cycle, in the cycle after the hit is sampled. The record carries the electron pixel and time and the proton pixel and time.
- R5: When several unpaired candidates match one proton, the oldest one is paired. The other candidates stay open.
- R6: A proton that matches only paired candidates raises extra_valid_o one cycle after the hit, with the proton's pixel and time, and leaves the pairing unchanged.
- R7: The oldest candidate is retired once now_i minus its time exceeds WIN_MAX. If it is unpaired and singles_en_i is high, single_valid_o rises in the next cycle with its pixel and time. Paired candidates retire silently.
- R8: With singles_en_i low, retiring candidates raise no singles trigger.
- R9: An electron that arrives while DEPTH candidates are held evicts the oldest candidate, under the same singles rule as R7. The new electron is then stored.
- R10: A proton that matches no candidate produces no output.
- R11: coinc_valid_o and extra_valid_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| singles_en_i | input | 1 | Enables singles triggers for unpaired retiring candidates |
| now_i | input | TS_W | Current time in 10 ns ticks, non-decreasing |
| hit_valid_i | input | 1 | Hit strobe |
| hit_proton_i | input | 1 | 1 = proton-like hit, 0 = electron-like hit |
| hit_pixel_i | input | PIX_W | Pixel index of the hit |
| hit_time_i | input | TS_W | Hit timestamp, non-decreasing, not after now_i |
| coinc_valid_o | output | 1 | Coincidence event record valid |
| coinc_e_pixel_o | output | PIX_W | Electron pixel of the event |
| coinc_e_time_o | output | TS_W | Electron timestamp of the event |
| coinc_p_pixel_o | output | PIX_W | Proton pixel of the event |
| coinc_p_time_o | output | TS_W | Proton timestamp of the event |
| extra_valid_o | output | 1 | Extra proton hit on already paired candidates |
| extra_pixel_o | output | PIX_W | Pixel of the extra proton |
| extra_time_o | output | TS_W | Timestamp of the extra proton |
| single_valid_o | output | 1 | Singles trigger for an unmatched electron |
| single_pixel_o | output | PIX_W | Pixel of the retired electron |
| single_time_o | output | TS_W | Timestamp of the retired electron |

## Verification
The hardest situations to reach are the exact edges of the delay window and eviction from a full queue. The window edges hinge on single-tick differences between a candidate's age and a proton's delay. Eviction requires DEPTH electrons to stay alive at once.

The stimulus controls now_i directly. It places each proton at an exact tick offset from its electron: 1199, 1200, 4000 and 4001 ticks. At 4001 ticks, retirement and a failed match coincide in the same cycle. Nine electrons are packed within a few ticks to force an eviction. Large jumps of now_i then drain the queue, so every leftover candidate must surface as a singles trigger in age order, or must stay silent when paired or disabled.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

  typedef struct packed {
    logic              ok;
    logic signed [7:0] q;
    logic signed [7:0] r;
  } hex_pos_t;

  // row-major hexagon numbering -> axial coordinates
  function automatic hex_pos_t hex_coord(input int idx, input int radius);
    hex_pos_t p;
    int start;
    int len;
    int qmin;
    p     = '0;
    start = 0;
    for (int r = -radius; r <= radius; r++) begin
      len  = 2 * radius + 1 - ((r < 0) ? -r : r);
      qmin = (r < 0) ? (-radius - r) : -radius;
      if (idx >= start && idx < start + len) begin
        p.ok = 1'b1;
        p.q  = 8'(qmin + idx - start);
        p.r  = 8'(r);
      end
      start += len;
    end
    return p;
  endfunction

endpackage

// File: rtl/hex_adj.sv
module hex_adj
  import coinc_pkg::*;
#(
  parameter int RADIUS = 6,
  parameter int PIX_W  = 7
) (
  input  logic [PIX_W-1:0] pix_a_i,
  input  logic [PIX_W-1:0] pix_b_i,
  output logic             adj_o
);

  always_comb begin : b_adj
    hex_pos_t a;
    hex_pos_t b;
    int dq;
    int dr;
    a  = hex_coord(int'(pix_a_i), RADIUS);
    b  = hex_coord(int'(pix_b_i), RADIUS);
    dq = int'(a.q) - int'(b.q);
    dr = int'(a.r) - int'(b.r);
    adj_o = a.ok && b.ok &&
            dq >= -1 && dq <= 1 && dr >= -1 && dr <= 1 &&
            (dq + dr) >= -1 && (dq + dr) <= 1;
  end

endmodule

// File: rtl/cand_select.sv
module cand_select #(
  parameter int N = 8
) (
  input  logic [N-1:0] req_i,
  output logic         found_o,
  output logic [N-1:0] grant_o
);

  // lowest index = oldest entry
  always_comb begin
    grant_o = '0;
    found_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (req_i[k] && !found_o) begin
        grant_o[k] = 1'b1;
        found_o    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
  import coinc_pkg::*;
#(
  parameter int RADIUS  = 6,
  parameter int DEPTH   = 8,
  parameter int TS_W    = 32,
  parameter int WIN_MIN = 1200,
  parameter int WIN_MAX = 4000,
  localparam int NPIX   = 3 * RADIUS * (RADIUS + 1) + 1,
  localparam int PIX_W  = $clog2(NPIX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             singles_en_i,
  input  logic [TS_W-1:0]  now_i,
  input  logic             hit_valid_i,
  input  logic             hit_proton_i,
  input  logic [PIX_W-1:0] hit_pixel_i,
  input  logic [TS_W-1:0]  hit_time_i,
  output logic             coinc_valid_o,
  output logic [PIX_W-1:0] coinc_e_pixel_o,
  output logic [TS_W-1:0]  coinc_e_time_o,
  output logic [PIX_W-1:0] coinc_p_pixel_o,
  output logic [TS_W-1:0]  coinc_p_time_o,
  output logic             extra_valid_o,
  output logic [PIX_W-1:0] extra_pixel_o,
  output logic [TS_W-1:0]  extra_time_o,
  output logic             single_valid_o,
  output logic [PIX_W-1:0] single_pixel_o,
  output logic [TS_W-1:0]  single_time_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [TS_W-1:0] T_MIN = TS_W'(WIN_MIN);
  localparam logic [TS_W-1:0] T_MAX = TS_W'(WIN_MAX);

  // candidate queue, index 0 oldest, valid entries contiguous from 0
  logic [DEPTH-1:0] vld_q, vld_n, pair_q, pair_m, pair_n;
  logic [PIX_W-1:0] pix_q  [DEPTH];
  logic [PIX_W-1:0] pix_n  [DEPTH];
  logic [TS_W-1:0]  time_q [DEPTH];
  logic [TS_W-1:0]  time_n [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_n;

  logic             is_e, is_p;
  logic [DEPTH-1:0] match, match_free, grant;
  logic             found;
  logic             head_exp, pop, fire_single;
  logic [TS_W-1:0]  head_age;
  logic [PTR_W-1:0] push_idx;
  logic [PIX_W-1:0] sel_pix;
  logic [TS_W-1:0]  sel_time;

  assign is_e = hit_valid_i & ~hit_proton_i;
  assign is_p = hit_valid_i &  hit_proton_i;

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    logic            adj;
    logic [TS_W-1:0] dt;
    hex_adj #(.RADIUS(RADIUS), .PIX_W(PIX_W)) i_adj (
      .pix_a_i(pix_q[k]),
      .pix_b_i(hit_pixel_i),
      .adj_o  (adj)
    );
    assign dt            = hit_time_i - time_q[k];
    assign match[k]      = is_p & vld_q[k] & adj & (dt >= T_MIN) & (dt <= T_MAX);
    assign match_free[k] = match[k] & ~pair_q[k];
  end

  cand_select #(.N(DEPTH)) i_sel (
    .req_i  (match_free),
    .found_o(found),
    .grant_o(grant)
  );

  always_comb begin
    sel_pix  = '0;
    sel_time = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (grant[k]) begin
        sel_pix  = pix_q[k];
        sel_time = time_q[k];
      end
    end
  end

  assign head_age    = now_i - time_q[0];
  assign head_exp    = vld_q[0] & (head_age > T_MAX);
  assign pop         = head_exp | (is_e & vld_q[DEPTH-1]);
  assign pair_m      = pair_q | grant;
  assign fire_single = pop & ~pair_m[0] & singles_en_i;
  assign push_idx    = PTR_W'(cnt_q - CNT_W'(pop));
  assign cnt_n       = cnt_q - CNT_W'(pop) + CNT_W'(is_e);

  always_comb begin
    vld_n  = vld_q;
    pair_n = pair_m;
    pix_n  = pix_q;
    time_n = time_q;
    if (pop) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        vld_n[k]  = vld_q[k+1];
        pair_n[k] = pair_m[k+1];
        pix_n[k]  = pix_q[k+1];
        time_n[k] = time_q[k+1];
      end
      vld_n[DEPTH-1]  = 1'b0;
      pair_n[DEPTH-1] = 1'b0;
    end
    if (is_e) begin
      vld_n[push_idx]  = 1'b1;
      pair_n[push_idx] = 1'b0;
      pix_n[push_idx]  = hit_pixel_i;
      time_n[push_idx] = hit_time_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      pair_q <= '0;
      cnt_q  <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        pix_q[k]  <= '0;
        time_q[k] <= '0;
      end
    end else begin
      vld_q  <= vld_n;
      pair_q <= pair_n;
      cnt_q  <= cnt_n;
      pix_q  <= pix_n;
      time_q <= time_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coinc_valid_o   <= 1'b0;
      coinc_e_pixel_o <= '0;
      coinc_e_time_o  <= '0;
      coinc_p_pixel_o <= '0;
      coinc_p_time_o  <= '0;
      extra_valid_o   <= 1'b0;
      extra_pixel_o   <= '0;
      extra_time_o    <= '0;
      single_valid_o  <= 1'b0;
      single_pixel_o  <= '0;
      single_time_o   <= '0;
    end else begin
      coinc_valid_o   <= found;
      coinc_e_pixel_o <= sel_pix;
      coinc_e_time_o  <= sel_time;
      coinc_p_pixel_o <= hit_pixel_i;
      coinc_p_time_o  <= hit_time_i;
      extra_valid_o   <= ~found & (|match);
      extra_pixel_o   <= hit_pixel_i;
      extra_time_o    <= hit_time_i;
      single_valid_o  <= fire_single;
      single_pixel_o  <= pix_q[0];
      single_time_o   <= time_q[0];
    end
  end

  a_r11_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(coinc_valid_o && extra_valid_o));

  a_r3_tof_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coinc_valid_o |-> ((coinc_p_time_o - coinc_e_time_o) >= T_MIN &&
                       (coinc_p_time_o - coinc_e_time_o) <= T_MAX));

  a_r8_single_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_valid_o |-> $past(singles_en_i));

  a_r9_count_tracks_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH) && $countones(vld_q) == int'(cnt_q));

  a_r7_paired_stays_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_q & ~vld_q) == '0);

endmodule

// File: tb/test_coinc_trigger.sv
module test_coinc_trigger;

  localparam int DEPTH = 8;
  localparam int TS_W  = 32;
  localparam int PIX_W = 7;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             singles_en_i = 1'b1;
  logic [TS_W-1:0]  now_i = '0;
  logic             hit_valid_i = 1'b0;
  logic             hit_proton_i = 1'b0;
  logic [PIX_W-1:0] hit_pixel_i = '0;
  logic [TS_W-1:0]  hit_time_i = '0;
  logic             coinc_valid_o, extra_valid_o, single_valid_o;
  logic [PIX_W-1:0] coinc_e_pixel_o, coinc_p_pixel_o, extra_pixel_o, single_pixel_o;
  logic [TS_W-1:0]  coinc_e_time_o, coinc_p_time_o, extra_time_o, single_time_o;

  always #2 clk = ~clk;

  coinc_trigger #(.DEPTH(DEPTH), .TS_W(TS_W)) i_coinc_trigger (
    .clk_i(clk), .rst_ni, .singles_en_i, .now_i,
    .hit_valid_i, .hit_proton_i, .hit_pixel_i, .hit_time_i,
    .coinc_valid_o, .coinc_e_pixel_o, .coinc_e_time_o, .coinc_p_pixel_o, .coinc_p_time_o,
    .extra_valid_o, .extra_pixel_o, .extra_time_o,
    .single_valid_o, .single_pixel_o, .single_time_o
  );

  typedef struct {
    int    kind;   // 0 coinc, 1 extra, 2 single
    int    pa;
    int    pb;
    longint ta;
    longint tb;
    string req;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  function automatic void push(int kind, int pa, longint ta, int pb, longint tb, string req);
    exp_t e;
    e.kind = kind; e.pa = pa; e.ta = ta; e.pb = pb; e.tb = tb; e.req = req;
    sb.push_back(e);
  endfunction

  function automatic void chk_out(int kind, int pa, longint ta, int pb, longint tb);
    exp_t e;
    n_chk++;
    if (sb.size() == 0) begin
      n_fail++;
      $display("FAIL R10 unexpected output kind=%0d pa=%0d ta=%0d pb=%0d tb=%0d, expected none",
               kind, pa, ta, pb, tb);
      return;
    end
    e = sb.pop_front();
    if (e.kind != kind || e.pa != pa || e.ta != ta || e.pb != pb || e.tb != tb) begin
      n_fail++;
      $display("FAIL %s got kind=%0d pa=%0d ta=%0d pb=%0d tb=%0d, expected kind=%0d pa=%0d ta=%0d pb=%0d tb=%0d",
               e.req, kind, pa, ta, pb, tb, e.kind, e.pa, e.ta, e.pb, e.tb);
    end
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (coinc_valid_o)
        chk_out(0, int'(coinc_e_pixel_o), longint'(coinc_e_time_o),
                   int'(coinc_p_pixel_o), longint'(coinc_p_time_o));
      if (extra_valid_o)
        chk_out(1, 0, 0, int'(extra_pixel_o), longint'(extra_time_o));
      if (single_valid_o)
        chk_out(2, int'(single_pixel_o), longint'(single_time_o), 0, 0);
    end
  end

  task automatic hit(input int pix, input bit prot, input longint t);
    @(negedge clk);
    now_i        = TS_W'(t);
    hit_valid_i  = 1'b1;
    hit_proton_i = prot;
    hit_pixel_i  = PIX_W'(pix);
    hit_time_i   = TS_W'(t);
    @(negedge clk);
    hit_valid_i  = 1'b0;
  endtask

  task automatic flush(input string req);
    @(negedge clk);
    now_i = now_i + 32'd20000;
    repeat (DEPTH + 6) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL %s %0d expected outputs missing, expected 0", req, sb.size());
      sb.delete();
    end
  endtask

  function automatic longint base();
    return longint'(now_i) + 10;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    longint t;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    n_chk++;
    if (coinc_valid_o || extra_valid_o || single_valid_o) begin
      n_fail++;
      $display("FAIL R1 valids=%b%b%b, expected 000", coinc_valid_o, extra_valid_o, single_valid_o);
    end
    flush("R1_empty");

    // R2 R4: centre neighbour
    t = base();
    push(0, 63, t, 64, t + 2000, "R4");
    hit(63, 0, t);
    hit(64, 1, t + 2000);
    flush("R4");

    // R3 lower edge accepted, same pixel
    t = base();
    push(0, 0, t, 0, t + 1200, "R3_min");
    hit(0, 0, t);
    hit(0, 1, t + 1200);
    flush("R3_min");

    // R3 too early -> R10 nothing, then R7 single
    t = base();
    hit(8, 0, t);
    hit(8, 1, t + 1199);
    push(2, 8, t, 0, 0, "R7");
    flush("R3_early");

    // R3 upper edge accepted
    t = base();
    push(0, 20, t, 20, t + 4000, "R3_max");
    hit(20, 0, t);
    hit(20, 1, t + 4000);
    flush("R3_max");

    // R3/R7 one tick late: retired in same cycle, no coincidence
    t = base();
    hit(21, 0, t);
    push(2, 21, t, 0, 0, "R7_late");
    hit(21, 1, t + 4001);
    flush("R7_late");

    // R2 wrap across rows: 69 and 70 not adjacent
    t = base();
    hit(69, 0, t);
    hit(70, 1, t + 2000);
    push(2, 69, t, 0, 0, "R2_wrap");
    flush("R2_wrap");

    // R2 corner: 0 adjacent to 7, 2 not adjacent to 7
    t = base();
    push(0, 7, t, 0, t + 1300, "R2_corner");
    hit(7, 0, t);
    hit(0, 1, t + 1300);
    flush("R2_corner");
    t = base();
    hit(2, 0, t);
    hit(7, 1, t + 1300);
    push(2, 2, t, 0, 0, "R2_far");
    flush("R2_far");

    // R2 non-neighbour of centre: 49 and 77
    t = base();
    hit(63, 0, t);
    hit(49, 1, t + 1500);
    hit(77, 1, t + 1600);
    push(2, 63, t, 0, 0, "R2_nonadj");
    flush("R2_nonadj");

    // R6 extra hit after pairing; paired retires silently (R7)
    t = base();
    push(0, 50, t, 51, t + 1500, "R6_pair");
    hit(50, 0, t);
    hit(51, 1, t + 1500);
    push(1, 0, 0, 63, t + 1600, "R6");
    hit(63, 1, t + 1600);
    flush("R6_silent");

    // R5 oldest of two matching candidates paired
    t = base();
    push(0, 63, t, 63, t + 2000, "R5");
    hit(63, 0, t);
    hit(64, 0, t + 10);
    hit(63, 1, t + 2000);
    push(2, 64, t + 10, 0, 0, "R5_other_open");
    flush("R5");

    // R8 singles disabled
    singles_en_i = 1'b0;
    t = base();
    hit(30, 0, t);
    hit(31, 0, t + 5);
    flush("R8");
    singles_en_i = 1'b1;

    // R9 full queue eviction
    t = base();
    for (int k = 0; k < DEPTH; k++) hit(10 + k, 0, t + k);
    push(2, 10, t, 0, 0, "R9_evict");
    hit(10 + DEPTH, 0, t + DEPTH);
    for (int k = 1; k <= DEPTH; k++) push(2, 10 + k, t + k, 0, 0, "R9_drain");
    flush("R9");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule